// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns bus requests from a small 8-bit processor core into external bus cycles on a 16-bit address space. The upper address byte has pins of its own. The lower address byte and the data byte share one set of pins. The core presents a request with a kind, an address and write data. The block then runs a machine cycle of three or more clocks. It raises an address latch strobe in the first clock, so that external logic can catch the low address byte off the shared pins. It drives an encoded status on two lines, and pulses an active-low read or write strobe in the data clocks. The data clocks are stretched while the ready input stays low.

The block has five kinds of transfer: opcode fetch, memory read and write, and I/O read and write. A sixth kind, halt, runs an address clock and then parks the block with its bus released. A second bus master can ask for the bus through a hold input. The block grants the bus only on a machine-cycle boundary, signals the grant, floats its outputs, and takes the bus back one clock after the grant is withdrawn. Tri-state is shown as separate output-enable signals: one for the shared pins, and one for the upper address, the strobes and the memory/IO select. The core sees a one-clock completion pulse together with the returned read byte.

Top module: `muxbus_seq`

## Requirements
- R1: In the first clock (T1) of every machine cycle `ale` is high for exactly that clock. `ad_oe` and `bus_oe` are high, `ad_out` carries address bits 7:0 and `hi_addr` carries address bits 15:8. `ale` is low in every other clock.
- R2: `req_kind` codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write and 5 halt; codes 6 and 7 behave as memory reads. `status` (bit 1 = S1, bit 0 = S0) shows the current or last cycle as 11 fetch, 10 read, 01 write, 00 halt. `io_m` is 1 for the I/O kinds and 0 otherwise.
- R3: In a read or fetch cycle the shared pins are released (`ad_oe` = 0) from T2 through T3, and `rd_n` is low for the same clocks. `ad_in` is captured on the clock edge that ends the last T2/wait clock, and `rdata` holds that byte while `done` is high in T3.
- R4: In a write cycle `ad_out` carries the write data with `ad_oe` = 1 from T2 through T3. `wr_n` is low in those same clocks, so the data is valid before the strobe's trailing edge.
- R5: `rd_n` and `wr_n` are never low in the same clock.
- R6: `ready` is sampled only in T2 and in each wait clock. While it is low, a wait clock follows with the strobe still active and `done` low. T3, with `done` high for one clock, follows the first sampled clock in which `ready` is high.
- R7: `hold` is honoured only at the end of T3, in idle, or while halted. In the next clock `hlda` rises and `bus_oe` and `ad_oe` drop. `req_ready` is low whenever `hold` is high, and no request starts while `hlda` is high.
- R8: After `hold` falls, `hlda` drops at the next clock. The outputs stay released for that one clock, and `bus_oe` returns in the clock after.
- R9: A halt request runs a T1 with status 00 and then parks with `bus_oe` = 0, `ad_oe` = 0 and both strobes high until a new request is accepted. A hold granted while halted returns to the halted state.
- R10: A request accepted while `done` is high (T3) starts its T1 in the very next clock, with no idle clock between cycles.
- R11: After reset the block is idle: `ale` = 0, `rd_n` = `wr_n` = 1, `hlda` = 0, `done` = 0, `bus_oe` = 1, `ad_oe` = 0, `status` = 11 and `req_ready` = 1 while `hold` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one clock per T-state |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core has a request pending |
| req_kind | input | 3 | Transfer kind code |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request is accepted at this clock edge if `req_valid` is high |
| done | output | 1 | Completion pulse during T3 |
| rdata | output | DATA_W | Byte returned by the last read |
| hi_addr | output | ADDR_W-DATA_W | Upper address pins |
| ad_out | output | DATA_W | Shared address/data pins, driven value |
| ad_in | input | DATA_W | Shared address/data pins, received value |
| ad_oe | output | 1 | Drive enable for the shared pins |
| ale | output | 1 | Address latch strobe |
| status | output | 2 | Encoded cycle status {S1,S0} |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | 1 = I/O space, 0 = memory |
| bus_oe | output | 1 | Drive enable for upper address, strobes and `io_m` |
| ready | input | 1 | Target ready; low inserts wait clocks |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant to the other master |

## Verification
A wrong cycle state shows at the pins within the same clock. A sequence that skips T2 or leaves a wait clock too early gives a strobe that is too short, or a `done` that comes before the bench released `ready`. A stale latched kind gives the wrong `status` or `io_m` already in T1. A hold or halt state that is entered at the wrong time leaves `bus_oe` high while `hlda` is up, or keeps the outputs released one clock too long after the grant falls. The bench checks every clock of each cycle, so any of these faults is reported within one clock.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_HALT, ST_HOLD, ST_REBUS
   } bstate_e;

   localparam logic [2:0] K_FETCH = 3'd0;
   localparam logic [2:0] K_MRD   = 3'd1;
   localparam logic [2:0] K_MWR   = 3'd2;
   localparam logic [2:0] K_IORD  = 3'd3;
   localparam logic [2:0] K_IOWR  = 3'd4;
   localparam logic [2:0] K_HALT  = 3'd5;

   function automatic logic kind_is_write(input logic [2:0] k);
      return (k == K_MWR) || (k == K_IOWR);
   endfunction

   function automatic logic kind_is_io(input logic [2:0] k);
      return (k == K_IORD) || (k == K_IOWR);
   endfunction

   function automatic logic kind_is_halt(input logic [2:0] k);
      return k == K_HALT;
   endfunction

   // {S1,S0}: halt 00, write 01, read 10, fetch 11
   function automatic logic [1:0] kind_status(input logic [2:0] k);
      if (kind_is_halt(k))       return 2'b00;
      else if (kind_is_write(k)) return 2'b01;
      else if (k == K_FETCH)     return 2'b11;
      else                       return 2'b10;
   endfunction

endpackage

// File: rtl/mbs_cycle_fsm.sv
module mbs_cycle_fsm
   import mbs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       ready,
   input  logic       hold,
   input  logic [2:0] kind_q,
   output bstate_e    state,
   output logic       req_ready,
   output logic       load,
   output logic       capture
);

   bstate_e nxt;
   logic    boundary;

   // machine-cycle boundaries: where a new request or a hold may take effect
   assign boundary  = (state == ST_IDLE) || (state == ST_T3) || (state == ST_HALT);
   assign req_ready = boundary && !hold;
   assign load      = req_ready && req_valid;
   assign capture   = ((state == ST_T2) || (state == ST_TW)) && ready
                      && !kind_is_write(kind_q);

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE, ST_T3, ST_HALT: begin
            if (hold)              nxt = ST_HOLD;
            else if (req_valid)    nxt = ST_T1;
            else if (state == ST_T3) nxt = ST_IDLE;
         end
         ST_T1:    nxt = kind_is_halt(kind_q) ? ST_HALT : ST_T2;
         ST_T2,
         ST_TW:    nxt = ready ? ST_T3 : ST_TW;
         ST_HOLD:  nxt = hold ? ST_HOLD : ST_REBUS;
         ST_REBUS: nxt = kind_is_halt(kind_q) ? ST_HALT : ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

endmodule

// File: rtl/mbs_req_latch.sv
module mbs_req_latch
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [2:0]        kind_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              capture,
   input  logic [DATA_W-1:0] ad_in,
   output logic [2:0]        kind_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= K_FETCH;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (load) begin
            kind_q  <= kind_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
         end
         if (capture) rdata_q <= ad_in;
      end
   end

endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  bstate_e                  state,
   input  logic [2:0]               kind_q,
   input  logic [ADDR_W-1:0]        addr_q,
   input  logic [DATA_W-1:0]        wdata_q,
   output logic                     ale,
   output logic                     ad_oe,
   output logic [DATA_W-1:0]        ad_out,
   output logic [ADDR_W-DATA_W-1:0] hi_addr,
   output logic                     bus_oe,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     io_m,
   output logic [1:0]               status,
   output logic                     hlda,
   output logic                     done
);

   logic addr_clk, data_clk, owns_bus, wr_k;

   always_comb begin
      addr_clk = (state == ST_T1);
      data_clk = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
      owns_bus = (state == ST_IDLE) || addr_clk || data_clk;
      wr_k     = kind_is_write(kind_q);

      ale     = addr_clk;
      bus_oe  = owns_bus;
      ad_oe   = addr_clk || (data_clk && wr_k);
      ad_out  = addr_clk ? addr_q[DATA_W-1:0] : wdata_q;
      hi_addr = addr_q[ADDR_W-1:DATA_W];
      rd_n    = !(data_clk && !wr_k);
      wr_n    = !(data_clk && wr_k);
      io_m    = kind_is_io(kind_q);
      status  = kind_status(kind_q);
      hlda    = (state == ST_HOLD);
      done    = (state == ST_T3);
   end

endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [2:0]               req_kind,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     req_ready,
   output logic                     done,
   output logic [DATA_W-1:0]        rdata,
   output logic [ADDR_W-DATA_W-1:0] hi_addr,
   output logic [DATA_W-1:0]        ad_out,
   input  logic [DATA_W-1:0]        ad_in,
   output logic                     ad_oe,
   output logic                     ale,
   output logic [1:0]               status,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     io_m,
   output logic                     bus_oe,
   input  logic                     ready,
   input  logic                     hold,
   output logic                     hlda
);

   localparam int HI_W = ADDR_W - DATA_W;

   if (DATA_W < 1 || HI_W < 1) begin : g_bad_widths
      $error("muxbus_seq: ADDR_W must exceed DATA_W and DATA_W must be positive");
   end

   bstate_e           state;
   logic              load, capture;
   logic [2:0]        kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   mbs_cycle_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .ready     (ready),
      .hold      (hold),
      .kind_q    (kind_q),
      .state     (state),
      .req_ready (req_ready),
      .load      (load),
      .capture   (capture)
   );

   mbs_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .kind_in  (req_kind),
      .addr_in  (req_addr),
      .wdata_in (req_wdata),
      .capture  (capture),
      .ad_in    (ad_in),
      .kind_q   (kind_q),
      .addr_q   (addr_q),
      .wdata_q  (wdata_q),
      .rdata_q  (rdata)
   );

   mbs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .state   (state),
      .kind_q  (kind_q),
      .addr_q  (addr_q),
      .wdata_q (wdata_q),
      .ale     (ale),
      .ad_oe   (ad_oe),
      .ad_out  (ad_out),
      .hi_addr (hi_addr),
      .bus_oe  (bus_oe),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .io_m    (io_m),
      .status  (status),
      .hlda    (hlda),
      .done    (done)
   );

endmodule

// File: rtl/muxbus_seq_checks.sv
module muxbus_seq_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       ale,
   input logic       ad_oe,
   input logic       bus_oe,
   input logic       rd_n,
   input logic       wr_n,
   input logic       ready,
   input logic       done,
   input logic       hlda,
   input logic       req_ready,
   input logic [1:0] status
);

   p_ale_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   p_ale_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ad_oe && bus_oe));

   p_read_floats_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   p_done_strobed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!rd_n || !wr_n));

   p_write_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> ad_oe);

   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   p_wait_stretch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((!rd_n || !wr_n) && !done && !ready) |=> ((!rd_n || !wr_n) && !done));

   p_grant_floats_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> (!bus_oe && !ad_oe && !req_ready));

   p_release_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hlda) |-> !bus_oe);

   p_halt_floats_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'b00 && !ale) |-> (!bus_oe && !ad_oe));

endmodule

bind muxbus_seq muxbus_seq_checks u_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .ale       (ale),
   .ad_oe     (ad_oe),
   .bus_oe    (bus_oe),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .ready     (ready),
   .done      (done),
   .hlda      (hlda),
   .req_ready (req_ready),
   .status    (status)
);

// File: tb/muxbus_seq_bench.sv
`timescale 1ns/1ps
module muxbus_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_kind = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0] req_wdata = 8'h0;
   logic       req_ready, done;
   logic [7:0] rdata, hi_addr, ad_out;
   logic [7:0] ad_in = 8'h00;
   logic       ad_oe, ale, rd_n, wr_n, io_m, bus_oe, hlda;
   logic [1:0] status;
   logic       ready = 1'b1;
   logic       hold = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   muxbus_seq u_muxbus_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .done(done), .rdata(rdata), .hi_addr(hi_addr), .ad_out(ad_out),
      .ad_in(ad_in), .ad_oe(ad_oe), .ale(ale), .status(status),
      .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .bus_oe(bus_oe),
      .ready(ready), .hold(hold), .hlda(hlda)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_status(input logic [2:0] k);
      if (k == 3'd5) return 2'b00;
      if (k == 3'd2 || k == 3'd4) return 2'b01;
      if (k == 3'd0) return 2'b11;
      return 2'b10;
   endfunction

   // runs one transfer; returns at the negedge inside T3
   task automatic do_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] rv,
                           input int nwait, input bit hold_mid);
      bit is_wr;
      is_wr = (k == 3'd2 || k == 3'd4);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
      ready = (nwait == 0);
      @(negedge clk);                              // T1
      req_valid = 1'b0;
      chk("R1 ale in T1", ale, 1);
      chk("R1 ad_oe in T1", ad_oe, 1);
      chk("R1 low address", ad_out, a[7:0]);
      chk("R1 high address", hi_addr, a[15:8]);
      chk("R1 bus_oe in T1", bus_oe, 1);
      chk("R2 status", status, exp_status(k));
      chk("R2 io_m", io_m, (k == 3'd3 || k == 3'd4));
      @(negedge clk);                              // T2
      if (hold_mid) hold = 1'b1;
      chk("R1 ale low in T2", ale, 0);
      chk("R6 done low in T2", done, 0);
      if (is_wr) begin
         chk("R4 wr_n in T2", wr_n, 0);
         chk("R4 data on bus", ad_out, wd);
         chk("R4 ad_oe in T2", ad_oe, 1);
         chk("R5 rd_n high in write", rd_n, 1);
      end else begin
         ad_in = rv;
         chk("R3 rd_n in T2", rd_n, 0);
         chk("R3 bus released", ad_oe, 0);
         chk("R5 wr_n high in read", wr_n, 1);
      end
      for (int i = 1; i <= nwait; i++) begin
         @(negedge clk);                           // wait clock i
         chk("R6 strobe held in wait", is_wr ? wr_n : rd_n, 0);
         chk("R6 done low in wait", done, 0);
         if (hold_mid) chk("R7 no grant mid-cycle", hlda, 0);
         ready = (i == nwait);
      end
      @(negedge clk);                              // T3
      chk("R6 done in T3", done, 1);
      chk("R6 strobe in T3", is_wr ? wr_n : rd_n, 0);
      if (!is_wr) chk("R3 read data", rdata, rv);
      if (hold_mid) begin
         chk("R7 hlda low in T3", hlda, 0);
         chk("R7 req_ready low under hold", req_ready, 0);
      end
   endtask

   task automatic t_reset;
      chk("R11 ale", ale, 0);
      chk("R11 rd_n", rd_n, 1);
      chk("R11 wr_n", wr_n, 1);
      chk("R11 hlda", hlda, 0);
      chk("R11 done", done, 0);
      chk("R11 bus_oe", bus_oe, 1);
      chk("R11 ad_oe", ad_oe, 0);
      chk("R11 status", status, 2'b11);
      chk("R11 req_ready", req_ready, 1);
   endtask

   task automatic t_single(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] rv, input int nwait);
      do_cycle(k, a, wd, rv, nwait, 1'b0);
      @(negedge clk);                              // idle
      chk("R3 strobes idle rd_n", rd_n, 1);
      chk("R4 strobes idle wr_n", wr_n, 1);
      chk("R6 single done pulse", done, 0);
      chk("R1 ale idle", ale, 0);
      chk("R2 status kept", status, exp_status(k));
   endtask

   task automatic t_back2back;
      do_cycle(3'd1, 16'h1234, 8'h00, 8'h5A, 0, 1'b0);
      chk("R10 req_ready in T3", req_ready, 1);
      do_cycle(3'd2, 16'h4321, 8'hC3, 8'h00, 1, 1'b0);   // its T1 is the next clock
      @(negedge clk);
      chk("R10 idle after pair", ale, 0);
   endtask

   task automatic t_hold_mid;
      do_cycle(3'd3, 16'h00F0, 8'h00, 8'h77, 2, 1'b1);
      req_valid = 1'b1; req_kind = 3'd0; req_addr = 16'hBEEF;
      @(negedge clk);                              // hold granted
      chk("R7 hlda", hlda, 1);
      chk("R7 bus_oe floated", bus_oe, 0);
      chk("R7 ad_oe floated", ad_oe, 0);
      chk("R7 req_ready low", req_ready, 0);
      repeat (2) begin
         @(negedge clk);
         chk("R7 request ignored in hold", ale, 0);
         chk("R7 hlda stays", hlda, 1);
      end
      req_valid = 1'b0;
      hold = 1'b0;
      @(negedge clk);
      chk("R8 hlda dropped", hlda, 0);
      chk("R8 still floated", bus_oe, 0);
      @(negedge clk);
      chk("R8 bus retaken", bus_oe, 1);
      chk("R8 ready again", req_ready, 1);
   endtask

   task automatic t_halt;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd5; req_addr = 16'h0077;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 halt T1 ale", ale, 1);
      chk("R9 halt status", status, 2'b00);
      @(negedge clk);
      chk("R9 halted bus_oe", bus_oe, 0);
      chk("R9 halted ad_oe", ad_oe, 0);
      chk("R9 halted rd_n", rd_n, 1);
      chk("R9 halted wr_n", wr_n, 1);
      chk("R9 halted accepts", req_ready, 1);
      repeat (3) @(negedge clk);
      chk("R9 still halted", bus_oe, 0);
      hold = 1'b1;
      @(negedge clk);
      chk("R7 hold while halted", hlda, 1);
      hold = 1'b0;
      @(negedge clk);
      chk("R8 release gap from halt", bus_oe, 0);
      @(negedge clk);
      chk("R9 back to halted bus_oe", bus_oe, 0);
      chk("R9 back to halted status", status, 2'b00);
      t_single(3'd0, 16'h0100, 8'h00, 8'h3C, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single(3'd0, 16'hA55A, 8'h00, 8'h96, 0);
      t_single(3'd1, 16'h8001, 8'h00, 8'h1F, 3);
      t_single(3'd2, 16'h7FFE, 8'hE1, 8'h00, 2);
      t_single(3'd3, 16'h0042, 8'h00, 8'hD4, 1);
      t_single(3'd4, 16'h0099, 8'h2B, 8'h00, 0);
      t_single(3'd7, 16'h1357, 8'h00, 8'h68, 0);
      t_back2back();
      t_hold_mid();
      t_halt();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule